// File: doc/BRIEF.md
# Ping-Pong Frame Buffer Address Generator

This block produces the memory write addresses for pixel data coming from a camera serial receiver. Two frame buffers, ping and pong, are used in turn: while one is being written, the other holds the last finished image. The buffer switches after a programmable number of frame-end codes have arrived on one selected virtual channel. In progressive capture that number is one. In interlaced capture it is the number of fields that together form one progressive picture.

Every accepted line start on the selected channel sets a new line start address. When the stream carries a line number, the line is placed at the active buffer base plus the stride times that number, so that interlaced fields interleave into one progressive image. Without a line number, lines are laid out one after another. A nonzero stride is added to the previous line start. A zero stride continues directly after the last pixel word written. A pixel write address steps by one 32-bit word for each accepted pixel word. A status bit names the buffer that was completed last.

Top module: `fbuf_addr_gen`

## Requirements
- R1: After reset, `line_addr` and `pix_addr` are 0, the ping buffer is the one being written, and `buf_done` reads 1 (1 names pong, 0 names ping).
- R2: In the cycle after a 0-to-1 change of `enable`, ping is active and `buf_done` is 1. `line_addr` and `pix_addr` both equal `cfg_ping_base`, and the frame-end counter is cleared.
- R3: Each `fe_valid` with `fe_vc == cfg_vc` while enabled increments a counter. When the counter reaches `cfg_fe_count`, the other buffer becomes active, `buf_done` toggles and the counter returns to 0. If `cfg_fe_count` is 2, the first matching code does not switch buffers and the second one does.
- R4: Frame-end codes and line starts whose channel ID differs from `cfg_vc` change neither the buffer, nor the counter, nor any address.
- R5: The first line start after an enable rising edge or after a matching frame-end code begins at the active buffer base (`cfg_ping_base` when `buf_done` is 1, `cfg_pong_base` when it is 0).
- R6: With `cfg_ofst` nonzero and no line number, any later line starts at the previous line start plus `cfg_ofst` × 32 bytes.
- R7: With `cfg_ofst` zero and no line number, any later line starts at the current `pix_addr`, so the data is contiguous.
- R8: A line start with `ls_num_valid` set begins at the active base plus `cfg_ofst` × 32 × `ls_num`, whatever the first-line or stride state is.
- R9: Each `pix_valid` while enabled advances `pix_addr` by 4 bytes. When `pix_valid` arrives in the same cycle as a line start, `pix_addr` becomes that line start plus 4.
- R10: While `enable` is low, no strobe changes `line_addr`, `pix_addr` or `buf_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Interface enable; its rising edge restarts capture into ping |
| fe_valid | input | 1 | Frame-end code strobe |
| fe_vc | input | 2 | Virtual channel ID of the frame-end code |
| ls_valid | input | 1 | Line-start strobe |
| ls_vc | input | 2 | Virtual channel ID of the line start |
| ls_num_valid | input | 1 | The line start carries a line number |
| ls_num | input | 16 | Transmitted line number |
| pix_valid | input | 1 | One 32-bit pixel word accepted |
| cfg_ping_base | input | 32 | Ping buffer base byte address |
| cfg_pong_base | input | 32 | Pong buffer base byte address |
| cfg_ofst | input | 11 | Line stride in 32-byte units |
| cfg_fe_count | input | 8 | Frame-end codes per buffer switch |
| cfg_vc | input | 2 | Selected virtual channel |
| line_addr | output | 32 | Start address of the current line |
| pix_addr | output | 32 | Write address of the next pixel word |
| buf_done | output | 1 | Buffer completed last: 1 pong, 0 ping |

## Verification
The assertions assume that the configuration inputs are stable whenever a strobe they qualify is present. They also assume that a frame-end code and a line start on the selected channel never arrive in the same cycle, and that `cfg_fe_count` is nonzero. The stimulus changes configuration only in idle cycles that carry no strobe. It keeps frame-end codes and line starts in separate cycles and uses counts of 1 and 2. Pixel words are applied both alone and together with a line start, and that overlap is covered explicitly by R9.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;
    typedef enum logic {
        SEL_PING = 1'b0,
        SEL_PONG = 1'b1
    } buf_sel_e;
endpackage

// File: rtl/fbuf_swap_ctrl.sv
module fbuf_swap_ctrl
    import fbuf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             fe_hit,
    input  logic [CNT_W-1:0] cfg_count,
    output buf_sel_e         sel_o,
    output logic             swap_o
);
    typedef struct packed {
        buf_sel_e         sel;
        logic [CNT_W-1:0] cnt;
    } swap_state_t;

    swap_state_t st_d, st_q;
    logic [CNT_W:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        swap_o  = 1'b0;
        cnt_inc = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        if (restart) begin
            st_d.sel = SEL_PING;
            st_d.cnt = '0;
        end else if (fe_hit) begin
            if (cnt_inc == {1'b0, cfg_count}) begin
                swap_o   = 1'b1;
                st_d.sel = (st_q.sel == SEL_PING) ? SEL_PONG : SEL_PING;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = cnt_inc[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel <= SEL_PING;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_o = st_q.sel;
endmodule

// File: rtl/fbuf_line_calc.sv
module fbuf_line_calc #(
    parameter int ADDR_W     = 32,
    parameter int OFST_W     = 11,
    parameter int OFST_SHIFT = 5,
    parameter int LINE_W     = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFST_W-1:0] ofst,
    input  logic              num_valid,
    input  logic [LINE_W-1:0] num,
    input  logic              first,
    input  logic [ADDR_W-1:0] prev_line,
    input  logic [ADDR_W-1:0] cur_pix,
    output logic [ADDR_W-1:0] start
);
    localparam int OB_W = OFST_W + OFST_SHIFT;

    logic [OB_W-1:0]   ofst_raw;
    logic [ADDR_W-1:0] stride;
    logic [ADDR_W-1:0] num_ext;
    logic [ADDR_W-1:0] numbered;

    always_comb begin
        ofst_raw = {ofst, {OFST_SHIFT{1'b0}}};
        stride   = ADDR_W'(ofst_raw);
        num_ext  = ADDR_W'(num);
        numbered = base + stride * num_ext;
        if (num_valid) begin
            start = numbered;
        end else if (first) begin
            start = base;
        end else if (ofst == '0) begin
            start = cur_pix;
        end else begin
            start = prev_line + stride;
        end
    end
endmodule

// File: rtl/fbuf_addr_gen.sv
module fbuf_addr_gen
    import fbuf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int OFST_W     = 11,
    parameter int OFST_SHIFT = 5,
    parameter int LINE_W     = 16,
    parameter int CNT_W      = 8,
    parameter int VC_W       = 2,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              fe_valid,
    input  logic [VC_W-1:0]   fe_vc,
    input  logic              ls_valid,
    input  logic [VC_W-1:0]   ls_vc,
    input  logic              ls_num_valid,
    input  logic [LINE_W-1:0] ls_num,
    input  logic              pix_valid,
    input  logic [ADDR_W-1:0] cfg_ping_base,
    input  logic [ADDR_W-1:0] cfg_pong_base,
    input  logic [OFST_W-1:0] cfg_ofst,
    input  logic [CNT_W-1:0]  cfg_fe_count,
    input  logic [VC_W-1:0]   cfg_vc,
    output logic [ADDR_W-1:0] line_addr,
    output logic [ADDR_W-1:0] pix_addr,
    output logic              buf_done
);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(WORD_BYTES);

    typedef struct packed {
        logic              en;
        logic              first;
        logic [ADDR_W-1:0] line;
        logic [ADDR_W-1:0] pix;
    } addr_state_t;

    addr_state_t st_d, st_q;

    logic              restart;
    logic              fe_hit;
    logic              ls_hit;
    logic              swap;
    buf_sel_e          sel;
    logic [ADDR_W-1:0] active_base;
    logic [ADDR_W-1:0] line_start;
    logic [ADDR_W-1:0] pix_from;

    assign restart     = enable & ~st_q.en;
    assign fe_hit      = enable & st_q.en & fe_valid & (fe_vc == cfg_vc);
    assign ls_hit      = enable & ls_valid & (ls_vc == cfg_vc);
    assign active_base = (sel == SEL_PONG) ? cfg_pong_base : cfg_ping_base;

    fbuf_swap_ctrl #(
        .CNT_W (CNT_W)
    ) u_swap (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .fe_hit    (fe_hit),
        .cfg_count (cfg_fe_count),
        .sel_o     (sel),
        .swap_o    (swap)
    );

    fbuf_line_calc #(
        .ADDR_W     (ADDR_W),
        .OFST_W     (OFST_W),
        .OFST_SHIFT (OFST_SHIFT),
        .LINE_W     (LINE_W)
    ) u_line (
        .base      (active_base),
        .ofst      (cfg_ofst),
        .num_valid (ls_num_valid),
        .num       (ls_num),
        .first     (st_q.first),
        .prev_line (st_q.line),
        .cur_pix   (st_q.pix),
        .start     (line_start)
    );

    always_comb begin
        st_d     = st_q;
        st_d.en  = enable;
        pix_from = st_q.pix;
        if (restart) begin
            st_d.first = 1'b1;
            st_d.line  = cfg_ping_base;
            st_d.pix   = cfg_ping_base;
        end else if (enable) begin
            if (ls_hit) begin
                st_d.line  = line_start;
                st_d.first = 1'b0;
                pix_from   = line_start;
            end
            st_d.pix = pix_valid ? (pix_from + WORD_STEP) : pix_from;
            // a matching frame end (with or without a swap) rewinds line placement
            if (fe_hit || swap) begin
                st_d.first = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en    <= 1'b0;
            st_q.first <= 1'b1;
            st_q.line  <= '0;
            st_q.pix   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_addr = st_q.line;
    assign pix_addr  = st_q.pix;
    assign buf_done  = (sel == SEL_PING);
endmodule

// File: rtl/fbuf_addr_gen_chk.sv
module fbuf_addr_gen_chk #(
    parameter int ADDR_W     = 32,
    parameter int OFST_W     = 11,
    parameter int OFST_SHIFT = 5,
    parameter int LINE_W     = 16,
    parameter int CNT_W      = 8,
    parameter int VC_W       = 2,
    parameter int WORD_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              fe_valid,
    input logic [VC_W-1:0]   fe_vc,
    input logic              ls_valid,
    input logic [VC_W-1:0]   ls_vc,
    input logic              ls_num_valid,
    input logic [LINE_W-1:0] ls_num,
    input logic              pix_valid,
    input logic [ADDR_W-1:0] cfg_ping_base,
    input logic [ADDR_W-1:0] cfg_pong_base,
    input logic [OFST_W-1:0] cfg_ofst,
    input logic [CNT_W-1:0]  cfg_fe_count,
    input logic [VC_W-1:0]   cfg_vc,
    input logic [ADDR_W-1:0] line_addr,
    input logic [ADDR_W-1:0] pix_addr,
    input logic              buf_done
);
    logic              en_prev;
    logic              rise;
    logic              fe_match;
    logic              ls_match;
    logic              status_evt;
    logic [ADDR_W-1:0] exp_numbered;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_prev <= 1'b0;
        else        en_prev <= enable;
    end

    always_comb begin
        rise         = enable && !en_prev;
        fe_match     = enable && en_prev && fe_valid && (fe_vc == cfg_vc);
        ls_match     = enable && ls_valid && (ls_vc == cfg_vc);
        status_evt   = rise || fe_match;
        exp_numbered = (buf_done ? cfg_ping_base : cfg_pong_base)
                     + ((ADDR_W'(cfg_ofst) << OFST_SHIFT) * ADDR_W'(ls_num));
    end

    assert_restart_ping_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (buf_done && line_addr == $past(cfg_ping_base)
                  && pix_addr == $past(cfg_ping_base)));

    assert_idle_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ($stable(line_addr) && $stable(pix_addr) && $stable(buf_done)));

    assert_foreign_fe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && en_prev && fe_valid && fe_vc != cfg_vc && !ls_match)
        |=> $stable(buf_done));

    assert_status_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(buf_done) |-> $past(status_evt));

    assert_pix_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && en_prev && pix_valid && !ls_match)
        |=> pix_addr == $past(pix_addr) + ADDR_W'(WORD_BYTES));

    assert_numbered_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_prev && ls_match && ls_num_valid) |=> line_addr == $past(exp_numbered));
endmodule

bind fbuf_addr_gen fbuf_addr_gen_chk #(
    .ADDR_W     (ADDR_W),
    .OFST_W     (OFST_W),
    .OFST_SHIFT (OFST_SHIFT),
    .LINE_W     (LINE_W),
    .CNT_W      (CNT_W),
    .VC_W       (VC_W),
    .WORD_BYTES (WORD_BYTES)
) u_chk (.*);

// File: tb/fbuf_addr_gen_tb.sv
module fbuf_addr_gen_tb;
    localparam int      AW   = 32;
    localparam longint  WD   = 150000;
    localparam logic [AW-1:0] PING = 32'h1000_0000;
    localparam logic [AW-1:0] PONG = 32'h2000_0000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          enable, fe_valid, ls_valid, ls_num_valid, pix_valid;
    logic [1:0]    fe_vc, ls_vc, cfg_vc;
    logic [15:0]   ls_num;
    logic [AW-1:0] cfg_ping_base, cfg_pong_base;
    logic [10:0]   cfg_ofst;
    logic [7:0]    cfg_fe_count;
    logic [AW-1:0] line_addr, pix_addr;
    logic          buf_done;

    int tests  = 0;
    int fails  = 0;
    bit done   = 0;

    logic [AW-1:0] q_line[$];
    logic [AW-1:0] q_pix[$];
    logic          q_st[$];
    string         q_tag[$];

    logic          m_en = 0, m_sel = 0, m_first = 1;
    logic [7:0]    m_cnt = 0;
    logic [AW-1:0] m_line = 0, m_pix = 0;

    always #10 clk = ~clk;

    fbuf_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .fe_valid(fe_valid), .fe_vc(fe_vc),
        .ls_valid(ls_valid), .ls_vc(ls_vc),
        .ls_num_valid(ls_num_valid), .ls_num(ls_num),
        .pix_valid(pix_valid),
        .cfg_ping_base(cfg_ping_base), .cfg_pong_base(cfg_pong_base),
        .cfg_ofst(cfg_ofst), .cfg_fe_count(cfg_fe_count), .cfg_vc(cfg_vc),
        .line_addr(line_addr), .pix_addr(pix_addr), .buf_done(buf_done)
    );

    // reference model built from the requirements, then one expected item queued
    task automatic model_push(input string tag);
        logic [AW-1:0] base, start, pfrom;
        base = m_sel ? cfg_pong_base : cfg_ping_base;
        if (enable && !m_en) begin
            m_sel = 0; m_cnt = 0; m_first = 1;
            m_line = cfg_ping_base; m_pix = cfg_ping_base;
        end else if (enable) begin
            pfrom = m_pix;
            if (ls_valid && ls_vc == cfg_vc) begin
                if (ls_num_valid)        start = base + {16'd0, cfg_ofst, 5'd0} * {16'd0, ls_num};
                else if (m_first)        start = base;
                else if (cfg_ofst == 0)  start = m_pix;
                else                     start = m_line + {16'd0, cfg_ofst, 5'd0};
                m_line = start; pfrom = start; m_first = 0;
            end
            m_pix = pix_valid ? pfrom + 4 : pfrom;
            if (fe_valid && fe_vc == cfg_vc) begin
                m_first = 1;
                if (m_cnt + 8'd1 == cfg_fe_count) begin
                    m_cnt = 0; m_sel = ~m_sel;
                end else begin
                    m_cnt = m_cnt + 8'd1;
                end
            end
        end
        m_en = enable;
        q_line.push_back(m_line);
        q_pix.push_back(m_pix);
        q_st.push_back(~m_sel);
        q_tag.push_back(tag);
    endtask

    task automatic step(input logic en, input logic fv, input logic [1:0] fvc,
                        input logic lv, input logic [1:0] lvc, input logic nv,
                        input logic [15:0] num, input logic pv, input string tag);
        @(posedge clk); #5;
        enable = en; fe_valid = fv; fe_vc = fvc; ls_valid = lv; ls_vc = lvc;
        ls_num_valid = nv; ls_num = num; pix_valid = pv;
        model_push(tag);
    endtask

    task automatic set_cfg(input logic [10:0] ofst, input logic [7:0] cnt);
        @(posedge clk); #5;
        fe_valid = 0; ls_valid = 0; ls_num_valid = 0; pix_valid = 0;
        cfg_ofst = ofst; cfg_fe_count = cnt;
        model_push("cfg idle");
    endtask

    // monitor: compares outputs after each edge with the oldest queued item
    always @(posedge clk) begin
        #2;
        if (q_line.size() > 0) begin
            logic [AW-1:0] el, ep;
            logic          es;
            string         tg;
            el = q_line.pop_front(); ep = q_pix.pop_front();
            es = q_st.pop_front();   tg = q_tag.pop_front();
            tests++;
            if (line_addr !== el || pix_addr !== ep || buf_done !== es) begin
                fails++;
                $display("FAIL %s: line=%h pix=%h status=%b expected line=%h pix=%h status=%b",
                         tg, line_addr, pix_addr, buf_done, el, ep, es);
            end
        end
    end

    initial begin
        #(WD * 20);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; enable = 0; fe_valid = 0; fe_vc = 0; ls_valid = 0; ls_vc = 0;
        ls_num_valid = 0; ls_num = 0; pix_valid = 0;
        cfg_ping_base = PING; cfg_pong_base = PONG; cfg_ofst = 11'd3;
        cfg_fe_count = 8'd1; cfg_vc = 2'd1;
        repeat (3) @(posedge clk);
        #5 rst_n = 1;
        @(posedge clk); #5;
        tests++;
        if (line_addr !== 0 || pix_addr !== 0 || buf_done !== 1'b1) begin
            fails++;
            $display("FAIL R1: line=%h pix=%h status=%b expected 0 0 1", line_addr, pix_addr, buf_done);
        end

        step(1, 0, 0, 0, 0, 0, 0, 0, "R2 enable rise");
        step(1, 0, 0, 1, 1, 0, 0, 0, "R5 first line ping");
        step(1, 0, 0, 0, 0, 0, 0, 1, "R9 pixel word");
        step(1, 0, 0, 0, 0, 0, 0, 1, "R9 pixel word");
        step(1, 0, 0, 0, 0, 0, 0, 1, "R9 pixel word");
        step(1, 0, 0, 1, 1, 0, 0, 0, "R6 stride line");
        step(1, 0, 0, 1, 1, 0, 0, 1, "R9 pixel with line start");
        step(1, 0, 0, 1, 0, 0, 0, 0, "R4 foreign line start");
        step(1, 1, 2, 0, 0, 0, 0, 0, "R4 foreign frame end");
        step(1, 1, 1, 0, 0, 0, 0, 0, "R3 swap to pong");
        step(1, 0, 0, 1, 1, 0, 0, 0, "R5 first line pong");
        set_cfg(11'd0, 8'd1);
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 0, 0, 1, "R9 pixel word");
        step(1, 0, 0, 1, 1, 0, 0, 0, "R7 contiguous line");
        step(1, 0, 0, 0, 0, 0, 0, 1, "R9 pixel word");
        step(1, 0, 0, 1, 1, 0, 0, 0, "R7 contiguous line");
        set_cfg(11'd3, 8'd2);
        step(1, 0, 0, 1, 1, 1, 16'd7, 0, "R8 numbered line 7");
        step(1, 0, 0, 1, 1, 1, 16'd2, 1, "R8 numbered line 2");
        step(1, 0, 0, 1, 1, 1, 16'd0, 0, "R8 numbered line 0");
        step(1, 1, 1, 0, 0, 0, 0, 0, "R3 first of two, no swap");
        step(1, 1, 1, 0, 0, 0, 0, 0, "R3 second of two, swap");
        step(1, 0, 0, 1, 1, 1, 16'd5, 0, "R8 numbered line ping");
        step(1, 1, 1, 0, 0, 0, 0, 0, "R3 count one of two");
        step(0, 0, 0, 1, 1, 0, 0, 1, "R10 disabled line and pixel");
        step(0, 1, 1, 0, 0, 0, 0, 0, "R10 disabled frame end");
        step(0, 1, 1, 0, 0, 0, 0, 0, "R10 disabled frame end");
        step(0, 0, 0, 1, 1, 1, 16'd9, 1, "R10 disabled numbered line");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R2 re-enable");
        step(1, 1, 1, 0, 0, 0, 0, 0, "R2 counter cleared, no swap");
        step(1, 0, 0, 1, 1, 0, 0, 0, "R5 line after frame end");
        step(1, 0, 0, 0, 0, 0, 0, 0, "idle");
        repeat (3) @(posedge clk);
        #5;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule